// File: doc/BRIEF.md
# Variable-Length SPI Slave with Select-Latched Words

This block is the device side of a four-wire SPI link, running in mode 0. It contains two shift registers that run together. While the active-low select is held low, each rising serial clock edge shifts one MOSI bit into a receive register. Each falling serial clock edge moves the transmit register on by one bit, and the transmit register drives MISO. A frame has no fixed length. The master ends a frame by raising select, and at that moment the bits received so far become the received word. The block therefore accepts 8-, 13- or 16-bit words with no configuration.

All serial inputs pass through multi-stage synchronisers into the system clock domain before their edges are detected. The system clock must run at least four times faster than the serial clock. On the local side, a parallel word is captured when select falls and is sent MSB first. When the frame closes, the block presents the received word together with the number of bits counted, an overrun flag and a one-cycle valid strobe. MISO comes with an output enable so that a pad or the next level can tri-state the line while the block is not selected.

Top module: `spi_frame_slave`

## Requirements
- R1: After reset, `miso_oe`, `miso`, `rx_valid`, `rx_overrun`, `rx_count` and `rx_word` are all 0.
- R2: While `ss_n` is high, `miso_oe` and `miso` stay 0. Activity on `sclk` and `mosi` produces no `rx_valid` and leaves `rx_word` unchanged.
- R3: When `ss_n` falls, `tx_word` is captured and its bit 15 appears on `miso` with `miso_oe` = 1 before the first rising `sclk`. Each falling `sclk` presents the next lower bit. After all 16 bits have been sent, `miso` carries 0.
- R4: Each rising `sclk` while selected shifts `mosi` into bit 0 of the receive register, moving the earlier bits up. The first bit received therefore ends up as the most significant of the received bits.
- R5: Within 4 system clocks of `ss_n` rising, `rx_valid` is 1 for exactly one system clock. At the same time `rx_word` holds the received bits right-justified, with zeros above them, and `rx_count` holds the number of rising `sclk` edges in the frame.
- R6: Frames of 1, 8, 13 and 16 bits are all received correctly with no configuration. A frame with no clock edges reports a count of 0 and a word of 0.
- R7: If more than 16 rising edges arrive, `rx_word` keeps the last 16 bits, `rx_count` stays at 16 and `rx_overrun` is 1. In any frame of 16 bits or fewer, `rx_overrun` is 0.
- R8: `rx_word`, `rx_count` and `rx_overrun` hold their values between frame ends.
- R9: A change to `tx_word` after `ss_n` has fallen has no effect on the bits sent in that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the master (idle low) |
| mosi | input | 1 | Serial data from the master |
| ss_n | input | 1 | Active-low select; the frame spans low period |
| miso | output | 1 | Serial data to the master |
| miso_oe | output | 1 | Drive enable for MISO, high while selected |
| tx_word | input | TX_W (16) | Parallel word sent in the next frame |
| rx_word | output | RX_W (16) | Last received word, right-justified |
| rx_count | output | CNT_W (5) | Bit count of the last frame, saturated at RX_W |
| rx_overrun | output | 1 | Last frame held more than RX_W clocks |
| rx_valid | output | 1 | One-cycle strobe when a frame closes |

## Verification
A wrong transmit shift state is visible in the very next bit the master samples on MISO, half a serial period after the faulty falling edge. A wrong receive state or bit count is hidden for the length of the frame and only shows in `rx_word` and `rx_count` a few system cycles after select rises. For that reason the bench checks every frame end against a word and count it computes itself. Faults in the synchroniser or the edge detection show up as a missing or doubled `rx_valid` pulse, or as a bit count one away from the number of clocks driven.

// File: rtl/sfs_pkg.sv
package sfs_pkg;

   // Edge pulses produced for one synchronised serial signal
   typedef struct packed {
      logic rise;
      logic fall;
   } sfs_edge_t;

   // Bits needed to count from 0 up to and including w
   function automatic int unsigned sfs_count_bits(input int unsigned w);
      return $clog2(w + 1);
   endfunction

endpackage

// File: rtl/sfs_sync.sv
// Multi-stage synchroniser for one asynchronous input.
module sfs_sync #(
   parameter int unsigned STAGES  = 2,
   parameter bit          RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("sfs_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= RST_VAL;
            else        chain[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= RST_VAL;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/sfs_edge.sv
// Edge detector on an already synchronised signal; lvl is the delayed copy.
module sfs_edge
   import sfs_pkg::*;
#(
   parameter bit RST_VAL = 1'b0
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      d,
   output logic      lvl,
   output sfs_edge_t edg
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl <= RST_VAL;
      else        lvl <= d;
   end

   assign edg.rise = d & ~lvl;
   assign edg.fall = ~d & lvl;
endmodule

// File: rtl/sfs_tx.sv
// Transmit shift register: loaded at frame start, MSB first, fill bit after.
module sfs_tx #(
   parameter int unsigned TX_W = 16,
   parameter bit          FILL = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic            shift,
   input  logic [TX_W-1:0] par,
   output logic            sout
);
   if (TX_W < 2) begin : g_bad_w
      $error("sfs_tx: TX_W must be at least 2");
   end

   logic [TX_W-1:0] shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     shreg <= '0;
      else if (load)  shreg <= par;
      else if (shift) shreg <= {shreg[TX_W-2:0], FILL};
   end

   assign sout = shreg[TX_W-1];

   AST_TX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> shreg == $past(par)); // R3
   AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !shift) |=> $stable(shreg)); // R9
endmodule

// File: rtl/sfs_rx.sv
// Receive shift register with saturating bit count and frame-end latch.
module sfs_rx #(
   parameter int unsigned RX_W  = 16,
   parameter int unsigned CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             active,
   input  logic             sample,
   input  logic             bit_in,
   input  logic             finish,
   output logic [RX_W-1:0]  rx_word,
   output logic [CNT_W-1:0] rx_count,
   output logic             rx_overrun,
   output logic             rx_valid
);
   if (RX_W < 2) begin : g_bad_w
      $error("sfs_rx: RX_W must be at least 2");
   end
   if ((1 << CNT_W) <= RX_W) begin : g_bad_cnt
      $error("sfs_rx: CNT_W too narrow for RX_W");
   end

   localparam logic [CNT_W-1:0] FULL = CNT_W'(RX_W);

   logic [RX_W-1:0]  sh;
   logic [CNT_W-1:0] cnt;
   logic             ovf;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh  <= '0;
         cnt <= '0;
         ovf <= 1'b0;
      end else if (start) begin
         sh  <= '0;
         cnt <= '0;
         ovf <= 1'b0;
      end else if (sample && active) begin
         sh <= {sh[RX_W-2:0], bit_in};
         if (cnt == FULL) ovf <= 1'b1;
         else             cnt <= cnt + CNT_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_word    <= '0;
         rx_count   <= '0;
         rx_overrun <= 1'b0;
         rx_valid   <= 1'b0;
      end else begin
         rx_valid <= finish;
         if (finish) begin
            rx_word    <= sh;
            rx_count   <= cnt;
            rx_overrun <= ovf;
         end
      end
   end

   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (sample && active && !start && cnt != FULL) |=> cnt == $past(cnt) + CNT_W'(1)); // R4
   AST_OVR_AT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |-> cnt == FULL); // R7
   AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid); // R5
   AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !finish |=> ($stable(rx_word) && $stable(rx_count))); // R8
endmodule

// File: rtl/spi_frame_slave.sv
// SPI mode-0 slave whose word length is set by the select low period.
module spi_frame_slave
   import sfs_pkg::*;
#(
   parameter  int unsigned RX_W        = 16,
   parameter  int unsigned TX_W        = 16,
   parameter  int unsigned SYNC_STAGES = 2,
   parameter  bit          TX_FILL     = 1'b0,
   localparam int unsigned CNT_W       = sfs_count_bits(RX_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sclk,
   input  logic             mosi,
   input  logic             ss_n,
   output logic             miso,
   output logic             miso_oe,
   input  logic [TX_W-1:0]  tx_word,
   output logic [RX_W-1:0]  rx_word,
   output logic [CNT_W-1:0] rx_count,
   output logic             rx_overrun,
   output logic             rx_valid
);
   logic      sclk_s, mosi_s, ss_s;
   logic      sclk_lvl, ss_lvl;
   sfs_edge_t sclk_e, ss_e;
   logic      selected, tx_bit;

   sfs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
      .clk(clk), .rst_n(rst_n), .d(sclk), .q(sclk_s));
   sfs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_mosi (
      .clk(clk), .rst_n(rst_n), .d(mosi), .q(mosi_s));
   sfs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_ss (
      .clk(clk), .rst_n(rst_n), .d(ss_n), .q(ss_s));

   sfs_edge #(.RST_VAL(1'b0)) u_edge_sclk (
      .clk(clk), .rst_n(rst_n), .d(sclk_s), .lvl(sclk_lvl), .edg(sclk_e));
   sfs_edge #(.RST_VAL(1'b1)) u_edge_ss (
      .clk(clk), .rst_n(rst_n), .d(ss_s), .lvl(ss_lvl), .edg(ss_e));

   assign selected = ~ss_lvl;

   sfs_tx #(.TX_W(TX_W), .FILL(TX_FILL)) u_tx (
      .clk(clk), .rst_n(rst_n),
      .load(ss_e.fall),
      .shift(sclk_e.fall & selected),
      .par(tx_word),
      .sout(tx_bit));

   sfs_rx #(.RX_W(RX_W), .CNT_W(CNT_W)) u_rx (
      .clk(clk), .rst_n(rst_n),
      .start(ss_e.fall),
      .active(selected),
      .sample(sclk_e.rise),
      .bit_in(mosi_s),
      .finish(ss_e.rise),
      .rx_word(rx_word), .rx_count(rx_count),
      .rx_overrun(rx_overrun), .rx_valid(rx_valid));

   assign miso_oe = selected;
   assign miso    = selected & tx_bit;

   logic unused_lvl;
   assign unused_lvl = sclk_lvl;

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !miso_oe |-> !miso); // R2
   AST_VALID_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> !miso_oe); // R5
endmodule

// File: tb/sim_spi_frame_slave.sv
module sim_spi_frame_slave;
   localparam int HALF = 6;   // system clocks per serial half period
   localparam int NV   = 6;

   // Vector table: frame length, MOSI data (sent from bit len-1 down), parallel tx word
   localparam int          V_LEN  [NV] = '{8, 13, 16, 1, 20, 16};
   localparam logic [31:0] V_DATA [NV] = '{32'h000000A5, 32'h00001ABC, 32'h0000F00F,
                                           32'h00000001, 32'h000ABCDE, 32'h0000FFFF};
   localparam logic [15:0] V_TX   [NV] = '{16'hC3A5, 16'h8001, 16'h5AA5,
                                           16'hFFFF, 16'h1234, 16'h0000};

   logic        clk = 0, rst_n = 0;
   logic        sclk = 0, mosi = 0, ss_n = 1;
   logic [15:0] tx_word = '0;
   logic        miso, miso_oe, rx_overrun, rx_valid;
   logic [15:0] rx_word;
   logic [4:0]  rx_count;

   int checks = 0, fails = 0, cyc = 0;
   bit done = 0;

   always #10 clk = ~clk;   // 50 MHz

   spi_frame_slave u0 (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .mosi(mosi), .ss_n(ss_n),
      .miso(miso), .miso_oe(miso_oe), .tx_word(tx_word),
      .rx_word(rx_word), .rx_count(rx_count),
      .rx_overrun(rx_overrun), .rx_valid(rx_valid));

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         done = 1;
         fails++; checks++;
         $display("FAIL watchdog: actual cycles %0d expected < 150000", cyc);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Runs one frame; returns the MISO bits seen and the number of rx_valid pulses.
   task automatic frame(input int n, input logic [31:0] data, input logic [15:0] tx,
                        input bit change_tx, output logic [31:0] got, output int pulses,
                        output bit oe_ok);
      got = '0; oe_ok = 1; pulses = 0;
      @(negedge clk);
      tx_word = tx;
      ss_n = 0;
      wait_n(HALF);
      for (int i = 0; i < n; i++) begin
         mosi = data[n-1-i];
         wait_n(HALF);
         got = {got[30:0], miso};
         if (!miso_oe) oe_ok = 0;
         sclk = 1;
         wait_n(HALF);
         sclk = 0;
         if (change_tx && i == 2) tx_word = ~tx;
      end
      wait_n(HALF);
      ss_n = 1;
      for (int k = 0; k < 12; k++) begin
         @(negedge clk);
         if (rx_valid) pulses++;
      end
   endtask

   function automatic logic [31:0] exp_miso(input int n, input logic [15:0] tx);
      logic [31:0] e = '0;
      for (int i = 0; i < n; i++) e = {e[30:0], (i < 16) ? tx[15-i] : 1'b0};
      return e;
   endfunction

   function automatic logic [15:0] exp_rx(input int n, input logic [31:0] d);
      if (n >= 16) return d[15:0];
      return 16'(d & ((32'd1 << n) - 1));
   endfunction

   initial begin
      logic [31:0] got;
      int          pulses;
      bit          oe_ok;
      logic [15:0] held;

      wait_n(3);
      // R1: reset state
      chk(!miso_oe && !miso && !rx_valid && !rx_overrun, "R1 outputs idle",
          {miso_oe, miso, rx_valid, rx_overrun}, 0);
      chk(rx_word == 0 && rx_count == 0, "R1 word/count", {rx_word, 11'd0, rx_count}, 0);
      rst_n = 1;
      wait_n(4);

      // Table-driven frames: R3 R4 R5 R6 R7
      for (int v = 0; v < NV; v++) begin
         int n = V_LEN[v];
         int ec = (n > 16) ? 16 : n;
         frame(n, V_DATA[v], V_TX[v], 0, got, pulses, oe_ok);
         chk(got == exp_miso(n, V_TX[v]) && oe_ok, "R3 miso MSB first", got, exp_miso(n, V_TX[v]));
         chk(rx_word == exp_rx(n, V_DATA[v]), "R4 R6 rx_word", rx_word, exp_rx(n, V_DATA[v]));
         chk(rx_count == 5'(ec), "R5 rx_count", rx_count, ec);
         chk(rx_overrun == (n > 16), "R7 rx_overrun", rx_overrun, n > 16);
         chk(pulses == 1, "R5 single rx_valid", pulses, 1);
         wait_n(4);
      end

      // R2: idle activity with select high
      held = rx_word;
      oe_ok = 1; pulses = 0;
      for (int i = 0; i < 10; i++) begin
         mosi = i[0]; sclk = 1; wait_n(HALF);
         if (miso_oe || miso) oe_ok = 0;
         if (rx_valid) pulses++;
         sclk = 0; wait_n(HALF);
         if (miso_oe || miso) oe_ok = 0;
         if (rx_valid) pulses++;
      end
      chk(oe_ok, "R2 miso quiet while deselected", oe_ok, 1);
      chk(pulses == 0 && rx_word == held, "R2 no capture while deselected", rx_word, held);

      // R9: tx_word changed mid-frame
      frame(16, 32'h0000_1357, 16'hA1B2, 1, got, pulses, oe_ok);
      chk(got == 32'h0000A1B2, "R9 mid-frame tx change ignored", got, 32'h0000A1B2);

      // R8: outputs held between frames while other inputs move
      held = rx_word;
      tx_word = 16'h0F0F; mosi = 1;
      wait_n(40);
      chk(rx_word == held && rx_count == 5'd16 && !rx_valid, "R8 result held", rx_word, held);

      // R6: frame with no clock edges
      frame(0, 32'h0, 16'hFFFF, 0, got, pulses, oe_ok);
      chk(rx_count == 0 && rx_word == 0 && pulses == 1, "R6 empty frame",
          {rx_word, 11'd0, rx_count}, 0);

      // R7: overrun clears on a following short frame
      frame(17, 32'h0001_FFFF, 16'h0000, 0, got, pulses, oe_ok);
      chk(rx_overrun && rx_count == 5'd16 && rx_word == 16'hFFFF, "R7 17-bit overrun",
          {rx_overrun, rx_count}, {1'b1, 5'd16});
      frame(8, 32'h0000_0081, 16'h0000, 0, got, pulses, oe_ok);
      chk(!rx_overrun && rx_word == 16'h0081, "R7 overrun cleared", {rx_overrun, rx_word}, 16'h0081);

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule